// File: doc/BRIEF.md
# Three-Source Interrupt Flag Controller

This block collects interrupt events from three sources and turns them into one request line for a small processor core. The sources are a falling edge on an external interrupt pin, a change on any bit of an input port, and an overflow strobe from a timer. Each event sets its own sticky bit in a status register. Software clears a bit by writing to that register.

A mask register holds one enable bit per source. A global enable gates the combined request. The global enable comes on with an enable command or a return-from-interrupt command. It goes off with a disable command, and it also goes off by itself when the core signals that it has taken the interrupt. The external pin is shared with ordinary I/O. It raises events only while a pin-function select puts it in interrupt mode.

Both pin inputs pass through a synchronizer before edge or change detection. All outputs are registered.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `stat_q` bit 0 is the timer flag, bit 1 the port-change flag and bit 2 the external flag. Bits 7 to 3 always read 0. A flag value of 1 means a request is pending.
- R2: A cycle with `mask_we`=1 loads `mask_wdata[2:0]` into `mask_q[2:0]` at the next edge: bit 0 enables the timer, bit 1 port change, bit 2 external, and 1 means enabled. `mask_q[7:3]` always reads 0.
- R3: A cycle with `tmr_ovf`=1 sets `stat_q[0]` at the next clock edge.
- R4: With `pin_is_irq`=1, a high-to-low change on `ext_pin_n` sets `stat_q[2]`. The pin passes through two synchronizer stages and one reference register, so the flag shows after the third rising edge that follows the pin change.
- R5: With `pin_is_irq`=0, falling edges on `ext_pin_n` leave `stat_q[2]` unchanged.
- R6: A change in any bit of `port_pins` sets `stat_q[1]`, with the same three-edge latency as R4.
- R7: Flags are sticky. A cycle with `stat_we`=1 loads `stat_wdata[2:0]` into the flags, but a source event in that same cycle keeps its flag at 1.
- R8: The global enable is 0 after reset. `gie_set` or `gie_ret` sets it. `gie_clr` or `irq_ack` clears it, and a clear wins over a set in the same cycle.
- R9: `irq_req` is the registered value of the global enable ANDed with the OR over the three sources of (flag AND mask). It updates on the same edge as the flags and the global enable.
- R10: A cycle with `rst`=1 clears status, mask, global enable and `irq_req`. It resets the external pin reference to high and the port reference to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 1 | Shared external pin, active-low interrupt |
| port_pins | input | PORT_W | Port inputs watched for change |
| tmr_ovf | input | 1 | Timer overflow strobe |
| pin_is_irq | input | 1 | 1: shared pin acts as interrupt input |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| gie_set | input | 1 | Enable command |
| gie_ret | input | 1 | Return-from-interrupt command |
| gie_clr | input | 1 | Disable command |
| irq_ack | input | 1 | Core has accepted the interrupt |
| stat_q | output | 8 | Status register |
| mask_q | output | 8 | Mask register |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The properties assume that the command strobes, `irq_ack` and the register write strobes are synchronous to `clk`. The pins may be fully asynchronous. The properties also assume that `port_pins` is at zero while reset is held, so that leaving reset raises no change event. The stimulus therefore drives every input away from the rising edge, holds the port at zero during reset, and randomizes commands, writes and pin levels only after reset is released. Collisions between a clear and an event, and between a set and a clear of the global enable, are forced by directed steps and also arise from the random ones.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_TMR = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_EXT = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) st[g] <= RST_VAL;
        else     st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_event_det.sv
module irq_event_det
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin_n,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              tmr_ovf,
  input  logic              pin_is_irq,
  output logic [NSRC-1:0]   ev
);
  logic              ext_s, ext_prev;
  logic [PORT_W-1:0] port_s, port_prev;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_pin_n), .q(ext_s)
  );

  irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_port_sync (
    .clk(clk), .rst(rst), .d(port_pins), .q(port_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev  <= 1'b1;
      port_prev <= '0;
    end else begin
      ext_prev  <= ext_s;
      port_prev <= port_s;
    end
  end

  always_comb begin
    ev          = '0;
    ev[SRC_TMR] = tmr_ovf;
    ev[SRC_CHG] = |(port_s ^ port_prev);
    ev[SRC_EXT] = pin_is_irq & ext_prev & ~ext_s;
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  ev,
  input  logic             stat_we,
  input  logic [REG_W-1:0] stat_wdata,
  input  logic             mask_we,
  input  logic [REG_W-1:0] mask_wdata,
  output logic [NSRC-1:0]  flag_d,
  output logic [NSRC-1:0]  mask_d,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] mask_q
);
  localparam int PAD = REG_W - NSRC;

  logic [NSRC-1:0] flag_r, mask_r;
  logic            unused_wbits;

  assign unused_wbits = ^{stat_wdata[REG_W-1:NSRC], mask_wdata[REG_W-1:NSRC]};

  // an event always wins over a software write in the same cycle
  assign flag_d = (stat_we ? stat_wdata[NSRC-1:0] : flag_r) | ev;
  assign mask_d = mask_we ? mask_wdata[NSRC-1:0] : mask_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_r <= '0;
      mask_r <= '0;
    end else begin
      flag_r <= flag_d;
      mask_r <= mask_d;
    end
  end

  assign stat_q = {{PAD{1'b0}}, flag_r};
  assign mask_q = {{PAD{1'b0}}, mask_r};
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin_n,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              tmr_ovf,
  input  logic              pin_is_irq,
  input  logic              stat_we,
  input  logic [REG_W-1:0]  stat_wdata,
  input  logic              mask_we,
  input  logic [REG_W-1:0]  mask_wdata,
  input  logic              gie_set,
  input  logic              gie_ret,
  input  logic              gie_clr,
  input  logic              irq_ack,
  output logic [REG_W-1:0]  stat_q,
  output logic [REG_W-1:0]  mask_q,
  output logic              irq_req
);
  logic [NSRC-1:0] ev, flag_d, mask_d;
  logic            gie_q, gie_d;

  irq_event_det #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .port_pins(port_pins),
    .tmr_ovf(tmr_ovf), .pin_is_irq(pin_is_irq), .ev(ev)
  );

  irq_flag_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .ev(ev),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .flag_d(flag_d), .mask_d(mask_d),
    .stat_q(stat_q), .mask_q(mask_q)
  );

  // clear commands dominate set commands
  assign gie_d = (gie_q | gie_set | gie_ret) & ~(gie_clr | irq_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q   <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      gie_q   <= gie_d;
      irq_req <= gie_d & |(flag_d & mask_d);
    end
  end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_ovf,
  input logic             pin_is_irq,
  input logic             stat_we,
  input logic [REG_W-1:0] stat_wdata,
  input logic             mask_we,
  input logic [REG_W-1:0] mask_wdata,
  input logic             gie_clr,
  input logic             irq_ack,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] mask_q,
  input logic             irq_req
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    stat_q[REG_W-1:3] == '0 && mask_q[REG_W-1:3] == '0);

  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> mask_q[2:0] == $past(mask_wdata[2:0]));

  p_tmr_set_r3: assert property (@(posedge clk) disable iff (rst)
    tmr_ovf |=> stat_q[0]);

  p_ext_gated_r5: assert property (@(posedge clk) disable iff (rst)
    (!pin_is_irq && !stat_we && !stat_q[2]) |=> !stat_q[2]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_q[1] && !stat_we) |=> stat_q[1]);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_we && !stat_wdata[0] && !tmr_ovf) |=> !stat_q[0]);

  p_gie_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack || gie_clr) |=> !irq_req);

  p_req_source_r9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> |(stat_q[2:0] & mask_q[2:0]));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .tmr_ovf(tmr_ovf), .pin_is_irq(pin_is_irq),
  .stat_we(stat_we), .stat_wdata(stat_wdata), .mask_we(mask_we),
  .mask_wdata(mask_wdata), .gie_clr(gie_clr), .irq_ack(irq_ack),
  .stat_q(stat_q), .mask_q(mask_q), .irq_req(irq_req)
);

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin_n = 1'b1;
  logic [PW-1:0] port_pins = '0;
  logic tmr_ovf = 0, pin_is_irq = 0, stat_we = 0, mask_we = 0;
  logic gie_set = 0, gie_ret = 0, gie_clr = 0, irq_ack = 0;
  logic [7:0] stat_wdata = '0, mask_wdata = '0;
  logic [7:0] stat_q, mask_q;
  logic irq_req;

  always #10 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .port_pins(port_pins),
    .tmr_ovf(tmr_ovf), .pin_is_irq(pin_is_irq), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .gie_set(gie_set), .gie_ret(gie_ret), .gie_clr(gie_clr),
    .irq_ack(irq_ack), .stat_q(stat_q), .mask_q(mask_q), .irq_req(irq_req)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  // reference model state, built from the requirements
  logic e1, e2, ep;
  logic [PW-1:0] p1, p2, pp;
  logic [2:0] m_flag, m_mask;
  logic m_gie, m_req;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] events();
    logic [2:0] ev;
    ev[0] = tmr_ovf;
    ev[1] = |(p2 ^ pp);
    ev[2] = pin_is_irq & ep & ~e2;
    return ev;
  endfunction

  task automatic model_step();
    logic [2:0] nf, nm;
    logic ng;
    if (rst) begin
      e1 = 1; e2 = 1; ep = 1; p1 = '0; p2 = '0; pp = '0;
      m_flag = '0; m_mask = '0; m_gie = 0; m_req = 0;
    end else begin
      nf = (stat_we ? stat_wdata[2:0] : m_flag) | events();
      nm = mask_we ? mask_wdata[2:0] : m_mask;
      ng = (m_gie | gie_set | gie_ret) & ~(gie_clr | irq_ack);
      ep = e2; e2 = e1; e1 = ext_pin_n;
      pp = p2; p2 = p1; p1 = port_pins;
      m_flag = nf; m_mask = nm; m_gie = ng; m_req = ng & |(nf & nm);
    end
  endtask

  // inputs are set at a falling edge; this advances one cycle and compares
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R7 status", stat_q, {5'b0, m_flag});
    chk("R2 mask", mask_q, {5'b0, m_mask});
    chk("R9 request", {7'b0, irq_req}, {7'b0, m_req});
  endtask

  task automatic idle();
    tmr_ovf = 0; stat_we = 0; mask_we = 0;
    gie_set = 0; gie_ret = 0; gie_clr = 0; irq_ack = 0;
  endtask

  initial begin
    void'($urandom(32'd20240));
    @(negedge clk);
    cyc(); cyc();
    chk("R10 status after reset", stat_q, 8'h00);
    chk("R10 mask after reset", mask_q, 8'h00);
    chk("R10 request after reset", {7'b0, irq_req}, 8'h00);
    rst = 0;
    cyc();

    mask_we = 1; mask_wdata = 8'hFF; cyc(); idle();
    chk("R2 mask upper bits zero", mask_q, 8'h07);

    gie_set = 1; cyc(); idle();
    tmr_ovf = 1; cyc(); idle();
    chk("R3 timer flag", stat_q, 8'h01);
    chk("R1 upper status bits", {3'b0, stat_q[7:3]}, 8'h00);
    chk("R9 request raised", {7'b0, irq_req}, 8'h01);

    irq_ack = 1; cyc(); idle();
    chk("R8 ack drops request", {7'b0, irq_req}, 8'h00);
    chk("R7 flag sticky after ack", stat_q, 8'h01);

    stat_we = 1; stat_wdata = 8'h00; tmr_ovf = 1; cyc(); idle();
    chk("R7 event beats clear", stat_q, 8'h01);
    stat_we = 1; stat_wdata = 8'h00; cyc(); idle();
    chk("R7 clear", stat_q, 8'h00);

    pin_is_irq = 0; ext_pin_n = 0;
    repeat (4) cyc();
    chk("R5 ext ignored in I/O mode", stat_q, 8'h00);
    ext_pin_n = 1; repeat (3) cyc();

    pin_is_irq = 1; ext_pin_n = 0;
    cyc(); cyc();
    chk("R4 not yet at second edge", stat_q, 8'h00);
    cyc();
    chk("R4 ext flag at third edge", stat_q, 8'h04);
    ext_pin_n = 1;

    stat_we = 1; stat_wdata = 8'h00; cyc(); idle();
    port_pins = 8'h80; repeat (3) cyc();
    chk("R6 port change flag", stat_q, 8'h02);

    gie_set = 1; gie_clr = 1; cyc(); idle();
    chk("R8 clear wins over set", {7'b0, irq_req}, 8'h00);
    gie_ret = 1; cyc(); idle();
    chk("R8 return sets enable", {7'b0, irq_req}, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      ext_pin_n  = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) port_pins = port_pins ^ (8'h1 << ($urandom % 8));
      if ($urandom % 64 == 0) pin_is_irq = ~pin_is_irq;
      tmr_ovf    = ($urandom % 10) == 0;
      stat_we    = ($urandom % 6) == 0;
      stat_wdata = 8'($urandom);
      mask_we    = ($urandom % 12) == 0;
      mask_wdata = 8'($urandom);
      gie_set    = ($urandom % 9) == 0;
      gie_ret    = ($urandom % 11) == 0;
      gie_clr    = ($urandom % 10) == 0;
      irq_ack    = irq_req && ($urandom % 3 == 0);
      cyc();
    end
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule